// File: doc/BRIEF.md
# Trap and Interrupt Delegation Unit

This block sits beside the execute stage of a hart that runs in user, supervisor and machine privilege. On every clock edge it looks at the pending and enabled interrupt lines, the current privilege and the global interrupt enables. It also looks at an optional exception request from the pipeline. From these it decides whether a trap is taken, which mode handles it, and where fetch must go next.

When it takes a trap it presents, one cycle later, a redirect PC and a new privilege. It also presents the values that the status and trap registers of the handling mode must take: cause, exception PC, fault address, saved enable and saved privilege. A write strobe selects which register set is written. The status and delegation registers themselves live outside the block and are fed in as inputs.

Breakpoint exceptions can be diverted into debug mode. This is enabled per privilege level. The block keeps a two-state machine: `ST_RUN` for normal operation and `ST_DEBUG` for debug mode. The transition `ST_RUN -> ST_DEBUG` fires on an enabled breakpoint. The transition `ST_DEBUG -> ST_RUN` fires on a resume request that arrives without an exception in the same cycle. In every other case the state is held. While in `ST_DEBUG`, exceptions only redirect fetch, and interrupts are ignored.

Top module: `trap_unit`

## Requirements
- R1: A non-delegated interrupt (pending, enabled, and its delegation bit clear) qualifies only when the current privilege is below machine (encodings: user 0, supervisor 1, machine 3), or when it is machine and `mie_i` is 1.
- R2: A delegated interrupt (delegation bit set) is considered only when no non-delegated interrupt qualifies. It then qualifies when the privilege is user, or when it is supervisor and `sie_i` is 1.
- R3: Among the qualifying interrupts of the chosen group, the lowest bit index wins. `cause_o` is that index with bit XLEN-1 set. In `ST_RUN` a taken interrupt has priority over an exception request in the same cycle.
- R4: A trap is handled in supervisor mode when the privilege is user or supervisor and the delegation bit for the cause index is set. Exceptions use `exc_deleg_i` and interrupts use `irq_deleg_i`. Every other trap is handled in machine mode.
- R5: A supervisor trap raises `s_wr_o` and sets `new_pc_o` to `stvec_i` and `new_priv_o` to 1. It sets `epc_o` to `cur_pc_i`, `pie_o` to `sie_i`, and `pp_o` to the old privilege (0 or 1). The handling mode's enable is cleared.
- R6: A machine trap raises `m_wr_o` and sets `new_priv_o` to 3. It sets `epc_o` to `cur_pc_i`, `pie_o` to `mie_i`, and `pp_o` to the old privilege. The handling mode's enable is cleared.
- R7: The machine trap PC is `mtvec_i` with bit 0 cleared. When `mtvec_i[0]` is 1 and the trap is an interrupt, 4 times the cause index is added. Exceptions never add an offset.
- R8: In `ST_RUN`, an exception with code 3 (breakpoint) whose `ebrk_en_i` bit (indexed by the privilege encoding) is set enters debug mode instead of trapping. The effects are: `dbg_wr_o`, `new_pc_o` = DBG_ENTRY, `new_priv_o` = 3, `epc_o` = `cur_pc_i`, `pp_o` = old privilege, `cause_o` = 1, and the state becomes `ST_DEBUG`.
- R9: In `ST_DEBUG`, a breakpoint redirects to DBG_ENTRY and any other exception redirects to DBG_EXC, with `new_priv_o` = 3 and no write strobe. Interrupts produce no trap.
- R10: An exception that carries a fault address (`exc_has_tval_i`) raises `tval_wr_o` with `tval_o` in the same cycle as the other trap writes. Interrupts never raise `tval_wr_o`.
- R11: All outputs are registered. Results appear in the cycle after the edge that accepts the event. `trap_valid_o` and the strobes are high for that one cycle only, and at most one strobe is high at a time.
- R12: After reset, the state is `ST_RUN` and all outputs are 0. `dbg_resume_i` without an exception in `ST_DEBUG` returns the state to `ST_RUN`, after which interrupts are taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pend_i | input | NCAUSE | Pending interrupt lines |
| irq_en_i | input | NCAUSE | Per-line interrupt enables |
| irq_deleg_i | input | NCAUSE | Interrupt delegation to supervisor |
| exc_deleg_i | input | NCAUSE | Exception delegation to supervisor |
| cur_priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| stvec_i | input | XLEN | Supervisor trap target |
| mtvec_i | input | XLEN | Machine trap base, bit 0 selects vectored mode |
| ebrk_en_i | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| exc_valid_i | input | 1 | Exception request |
| exc_code_i | input | CW | Exception cause index |
| cur_pc_i | input | XLEN | PC of the faulting or interrupted instruction |
| exc_has_tval_i | input | 1 | Exception carries a fault address |
| exc_tval_i | input | XLEN | Fault address |
| dbg_resume_i | input | 1 | Leave debug mode |
| trap_valid_o | output | 1 | Redirect strobe |
| new_pc_o | output | XLEN | Redirect target |
| new_priv_o | output | 2 | Privilege after the event |
| m_wr_o | output | 1 | Write machine trap registers |
| s_wr_o | output | 1 | Write supervisor trap registers |
| dbg_wr_o | output | 1 | Write debug registers |
| cause_o | output | XLEN | Cause value to write |
| epc_o | output | XLEN | Exception PC to write |
| tval_wr_o | output | 1 | Write fault-address register of the handling mode |
| tval_o | output | XLEN | Fault address to write |
| pie_o | output | 1 | New saved enable of the handling mode |
| pp_o | output | 2 | New saved privilege |
| dbg_mode_o | output | 1 | State is `ST_DEBUG` |

## Verification
A state register stuck in or wrongly set to `ST_DEBUG` shows at the ports on the cycle after the next request. Interrupts then vanish, breakpoints land on DBG_ENTRY without `dbg_wr_o`, and other exceptions land on DBG_EXC instead of a trap vector. `dbg_mode_o` exposes the state directly one cycle after entry or resume. A wrong choice of group or priority shows up one cycle after the request, as a different cause index, target PC or write strobe. The sweeps therefore step through every privilege, enable pair and pending pattern, and compare each registered result against a model derived from the requirements.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_DEBUG = 1'b1
    } tu_state_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int DBG_CAUSE_SWBP = 1;

endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import trap_pkg::*;
#(
    parameter int NIRQ = 16,
    parameter int IW   = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0] pend_i,
    input  logic [NIRQ-1:0] en_i,
    input  logic [NIRQ-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    output logic            hit_o,
    output logic [IW-1:0]   idx_o
);

    logic            m_on, s_on;
    logic [NIRQ-1:0] m_set, s_set, cand;

    always_comb begin
        m_on  = (priv_i != PRIV_M) || mie_i;
        s_on  = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && sie_i);
        m_set = pend_i & en_i & ~deleg_i & {NIRQ{m_on}};
        s_set = pend_i & en_i & deleg_i & {NIRQ{s_on}};
        // machine group first, supervisor group only as fallback
        cand  = (|m_set) ? m_set : s_set;
        hit_o = |cand;
        idx_o = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (cand[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NCAUSE = 16,
    parameter int CW     = $clog2(NCAUSE)
) (
    input  logic              is_irq_i,
    input  logic [CW-1:0]     code_i,
    input  logic [1:0]        priv_i,
    input  logic [NCAUSE-1:0] exc_deleg_i,
    input  logic [NCAUSE-1:0] irq_deleg_i,
    input  logic [XLEN-1:0]   stvec_i,
    input  logic [XLEN-1:0]   mtvec_i,
    output logic              to_s_o,
    output logic [XLEN-1:0]   pc_o
);

    logic            deleg_bit;
    logic [XLEN-1:0] m_base, m_off;

    always_comb begin
        deleg_bit = is_irq_i ? irq_deleg_i[code_i] : exc_deleg_i[code_i];
        to_s_o    = ((priv_i == PRIV_U) || (priv_i == PRIV_S)) && deleg_bit;
        m_base    = {mtvec_i[XLEN-1:1], 1'b0};
        m_off     = (mtvec_i[0] && is_irq_i) ? (XLEN'(code_i) << 2) : '0;
        pc_o      = to_s_o ? stvec_i : (m_base + m_off);
    end

endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              NCAUSE    = 16,
    parameter int              BKPT_CODE = 3,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC   = 'h808,
    localparam int             CW        = $clog2(NCAUSE)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NCAUSE-1:0] irq_pend_i,
    input  logic [NCAUSE-1:0] irq_en_i,
    input  logic [NCAUSE-1:0] irq_deleg_i,
    input  logic [NCAUSE-1:0] exc_deleg_i,
    input  logic [1:0]        cur_priv_i,
    input  logic              mie_i,
    input  logic              sie_i,
    input  logic [XLEN-1:0]   stvec_i,
    input  logic [XLEN-1:0]   mtvec_i,
    input  logic [3:0]        ebrk_en_i,
    input  logic              exc_valid_i,
    input  logic [CW-1:0]     exc_code_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic              exc_has_tval_i,
    input  logic [XLEN-1:0]   exc_tval_i,
    input  logic              dbg_resume_i,
    output logic              trap_valid_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [1:0]        new_priv_o,
    output logic              m_wr_o,
    output logic              s_wr_o,
    output logic              dbg_wr_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o,
    output logic              tval_wr_o,
    output logic [XLEN-1:0]   tval_o,
    output logic              pie_o,
    output logic [1:0]        pp_o,
    output logic              dbg_mode_o
);

    tu_state_e       state_q, state_d;
    logic            irq_hit;
    logic [CW-1:0]   irq_idx;
    logic            run_mode, take_irq, take_exc, go_dbg, is_bkpt;
    logic [CW-1:0]   route_code;
    logic            route_to_s;
    logic [XLEN-1:0] route_pc, cause_v;

    irq_pick #(.NIRQ(NCAUSE), .IW(CW)) u_pick (
        .pend_i  (irq_pend_i),
        .en_i    (irq_en_i),
        .deleg_i (irq_deleg_i),
        .priv_i  (cur_priv_i),
        .mie_i   (mie_i),
        .sie_i   (sie_i),
        .hit_o   (irq_hit),
        .idx_o   (irq_idx)
    );

    always_comb begin
        run_mode   = (state_q == ST_RUN);
        is_bkpt    = (exc_code_i == CW'(BKPT_CODE));
        take_irq   = run_mode && irq_hit;
        go_dbg     = run_mode && !irq_hit && exc_valid_i && is_bkpt
                     && ebrk_en_i[cur_priv_i];
        take_exc   = run_mode && !irq_hit && exc_valid_i && !go_dbg;
        route_code = take_irq ? irq_idx : exc_code_i;
        cause_v    = XLEN'(route_code);
        cause_v[XLEN-1] = take_irq;
    end

    trap_route #(.XLEN(XLEN), .NCAUSE(NCAUSE), .CW(CW)) u_route (
        .is_irq_i    (take_irq),
        .code_i      (route_code),
        .priv_i      (cur_priv_i),
        .exc_deleg_i (exc_deleg_i),
        .irq_deleg_i (irq_deleg_i),
        .stvec_i     (stvec_i),
        .mtvec_i     (mtvec_i),
        .to_s_o      (route_to_s),
        .pc_o        (route_pc)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (go_dbg) state_d = ST_DEBUG;
            ST_DEBUG: if (dbg_resume_i && !exc_valid_i) state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    assign dbg_mode_o = (state_q == ST_DEBUG);

    // registered outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trap_valid_o <= 1'b0;
            new_pc_o     <= '0;
            new_priv_o   <= '0;
            m_wr_o       <= 1'b0;
            s_wr_o       <= 1'b0;
            dbg_wr_o     <= 1'b0;
            cause_o      <= '0;
            epc_o        <= '0;
            tval_wr_o    <= 1'b0;
            tval_o       <= '0;
            pie_o        <= 1'b0;
            pp_o         <= '0;
        end else begin
            trap_valid_o <= 1'b0;
            m_wr_o       <= 1'b0;
            s_wr_o       <= 1'b0;
            dbg_wr_o     <= 1'b0;
            tval_wr_o    <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (take_irq || take_exc) begin
                        trap_valid_o <= 1'b1;
                        new_pc_o     <= route_pc;
                        epc_o        <= cur_pc_i;
                        cause_o      <= cause_v;
                        if (route_to_s) begin
                            s_wr_o     <= 1'b1;
                            new_priv_o <= PRIV_S;
                            pie_o      <= sie_i;
                            pp_o       <= {1'b0, cur_priv_i[0]};
                        end else begin
                            m_wr_o     <= 1'b1;
                            new_priv_o <= PRIV_M;
                            pie_o      <= mie_i;
                            pp_o       <= cur_priv_i;
                        end
                        if (take_exc && exc_has_tval_i) begin
                            tval_wr_o <= 1'b1;
                            tval_o    <= exc_tval_i;
                        end
                    end else if (go_dbg) begin
                        trap_valid_o <= 1'b1;
                        dbg_wr_o     <= 1'b1;
                        new_pc_o     <= DBG_ENTRY;
                        new_priv_o   <= PRIV_M;
                        epc_o        <= cur_pc_i;
                        pp_o         <= cur_priv_i;
                        cause_o      <= XLEN'(DBG_CAUSE_SWBP);
                    end
                end
                ST_DEBUG: begin
                    if (exc_valid_i) begin
                        trap_valid_o <= 1'b1;
                        new_priv_o   <= PRIV_M;
                        new_pc_o     <= is_bkpt ? DBG_ENTRY : DBG_EXC;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [1:0]      cur_priv_i,
    input logic            exc_valid_i,
    input logic [XLEN-1:0] stvec_i,
    input logic            trap_valid_o,
    input logic [XLEN-1:0] new_pc_o,
    input logic [1:0]      new_priv_o,
    input logic            m_wr_o,
    input logic            s_wr_o,
    input logic            dbg_wr_o,
    input logic [XLEN-1:0] cause_o,
    input logic            tval_wr_o,
    input logic [1:0]      pp_o,
    input logic            dbg_mode_o
);

    AST_NO_S_FROM_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_priv_i == 2'd3 |=> !s_wr_o); // R4

    AST_S_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_wr_o |-> (new_pc_o == $past(stvec_i)) && (new_priv_o == 2'd1)); // R5

    AST_M_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_wr_o |-> (new_priv_o == 2'd3) && (pp_o == $past(cur_priv_i))); // R6

    AST_DBG_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_wr_o |-> (new_pc_o == DBG_ENTRY) && dbg_mode_o); // R8

    AST_DBG_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_mode_o && !exc_valid_i |=> !trap_valid_o); // R9

    AST_TVAL_EXC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tval_wr_o |-> !cause_o[XLEN-1] && (m_wr_o || s_wr_o)); // R10

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({m_wr_o, s_wr_o, dbg_wr_o})); // R11

    AST_STROBE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_wr_o || s_wr_o || dbg_wr_o) |-> trap_valid_o); // R11

endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cur_priv_i   (cur_priv_i),
    .exc_valid_i  (exc_valid_i),
    .stvec_i      (stvec_i),
    .trap_valid_o (trap_valid_o),
    .new_pc_o     (new_pc_o),
    .new_priv_o   (new_priv_o),
    .m_wr_o       (m_wr_o),
    .s_wr_o       (s_wr_o),
    .dbg_wr_o     (dbg_wr_o),
    .cause_o      (cause_o),
    .tval_wr_o    (tval_wr_o),
    .pp_o         (pp_o),
    .dbg_mode_o   (dbg_mode_o)
);

// File: tb/test_trap_unit.sv
module test_trap_unit;

    localparam int          XLEN   = 32;
    localparam int          NC     = 16;
    localparam int          CW     = 4;
    localparam logic [31:0] D_ENT  = 32'h0000_0800;
    localparam logic [31:0] D_EXC  = 32'h0000_0808;
    localparam logic [31:0] STVEC  = 32'h0000_4000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NC-1:0]   pend, en, ideleg, edeleg;
    logic [1:0]      priv;
    logic            mie, sie;
    logic [31:0]     stvec, mtvec;
    logic [3:0]      ebrk;
    logic            exv;
    logic [CW-1:0]   code;
    logic [31:0]     pc;
    logic            has_tval;
    logic [31:0]     tval;
    logic            resume;

    logic            t_valid, m_wr, s_wr, d_wr, tv_wr, pie, dmode;
    logic [31:0]     n_pc, cause, epc, tval_out;
    logic [1:0]      n_priv, pp;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    trap_unit #(.XLEN(XLEN), .NCAUSE(NC), .BKPT_CODE(3),
                .DBG_ENTRY(D_ENT), .DBG_EXC(D_EXC)) i_trap_unit (
        .clk_i(clk), .rst_ni(rst_n),
        .irq_pend_i(pend), .irq_en_i(en), .irq_deleg_i(ideleg),
        .exc_deleg_i(edeleg), .cur_priv_i(priv), .mie_i(mie), .sie_i(sie),
        .stvec_i(stvec), .mtvec_i(mtvec), .ebrk_en_i(ebrk),
        .exc_valid_i(exv), .exc_code_i(code), .cur_pc_i(pc),
        .exc_has_tval_i(has_tval), .exc_tval_i(tval), .dbg_resume_i(resume),
        .trap_valid_o(t_valid), .new_pc_o(n_pc), .new_priv_o(n_priv),
        .m_wr_o(m_wr), .s_wr_o(s_wr), .dbg_wr_o(d_wr), .cause_o(cause),
        .epc_o(epc), .tval_wr_o(tv_wr), .tval_o(tval_out), .pie_o(pie),
        .pp_o(pp), .dbg_mode_o(dmode)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: actual=%0d cycles expected=completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fire();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        pend = '0; en = '1; ideleg = '0; edeleg = '0; priv = 2'd3;
        mie = 1'b0; sie = 1'b0; stvec = STVEC; mtvec = 32'h0000_1000;
        ebrk = '0; exv = 1'b0; code = '0; pc = 32'h100; has_tval = 1'b0;
        tval = 32'hDEAD_0000; resume = 1'b0;
    endtask

    // expected outcome of a regular trap, from R4..R7 and R10
    task automatic expect_trap(input bit irq, input logic [3:0] idx,
                               input logic [1:0] p, input logic [NC-1:0] dlg,
                               input bit tv);
        bit          to_s;
        logic [31:0] exp_pc;
        to_s   = (p != 2'd3) && dlg[idx];
        exp_pc = to_s ? stvec
                      : ((mtvec & ~32'd1) + ((mtvec[0] && irq) ? 32'(idx) * 4 : 32'd0));
        chk("R11 valid", {31'd0, t_valid}, 32'd1);
        chk("R4 s_wr", {31'd0, s_wr}, {31'd0, to_s});
        chk("R4 m_wr", {31'd0, m_wr}, {31'd0, !to_s});
        chk("R11 no dbg_wr", {31'd0, d_wr}, 32'd0);
        chk("R5 R6 R7 new_pc", n_pc, exp_pc);
        chk("R5 R6 priv", {30'd0, n_priv}, to_s ? 32'd1 : 32'd3);
        chk("R3 cause", cause, irq ? (32'h8000_0000 | 32'(idx)) : 32'(idx));
        chk("R5 R6 epc", epc, pc);
        chk("R5 R6 pie", {31'd0, pie}, {31'd0, to_s ? sie : mie});
        chk("R5 R6 pp", {30'd0, pp}, {30'd0, p});
        chk("R10 tval_wr", {31'd0, tv_wr}, {31'd0, tv && !irq});
        if (tv && !irq) chk("R10 tval", tval_out, tval);
    endtask

    task automatic irq_case();
        logic [NC-1:0] eff, grp;
        bit            m_on, s_on, found;
        logic [3:0]    idx;
        fire();
        eff  = pend & en;
        m_on = (priv != 2'd3) || mie;                       // R1
        s_on = (priv == 2'd0) || ((priv == 2'd1) && sie);   // R2
        grp  = m_on ? (eff & ~ideleg) : '0;
        if (grp == '0) grp = s_on ? (eff & ideleg) : '0;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NC; i++) begin
            if (!found && grp[i]) begin
                found = 1'b1;
                idx   = 4'(i);
            end
        end
        if (found) expect_trap(1'b1, idx, priv, ideleg, 1'b0);
        else       chk("R1 R2 no interrupt taken", {31'd0, t_valid}, 32'd0);
    endtask

    initial begin
        logic [NC-1:0] pats [8];
        pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h0002; pats[3] = 16'h0080;
        pats[4] = 16'h0222; pats[5] = 16'hA0A0; pats[6] = 16'h8000; pats[7] = 16'hFFFF;

        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 reset valid", {31'd0, t_valid}, 32'd0);
        chk("R12 reset pc", n_pc, 32'd0);
        chk("R12 reset strobes", {29'd0, m_wr, s_wr, d_wr}, 32'd0);
        chk("R12 reset state", {31'd0, dmode}, 32'd0);

        // R1 R2 R3 R4 R5 R6 R7: interrupt sweep
        for (int p = 0; p < 3; p++) begin
            for (int e = 0; e < 4; e++) begin
                for (int k = 0; k < 8; k++) begin
                    for (int v = 0; v < 2; v++) begin
                        idle_inputs();
                        priv   = (p == 2) ? 2'd3 : 2'(p);
                        mie    = e[0];
                        sie    = e[1];
                        pend   = pats[k];
                        en     = v[0] ? 16'h00FF : 16'hFFFF;
                        ideleg = 16'h0222;
                        mtvec  = v[0] ? 32'h0000_2001 : 32'h0000_1000;
                        pc     = 32'h200 + 32'(k * 4);
                        irq_case();
                    end
                end
            end
        end

        // R4 R6 R7 R10: exception sweep, vectored mtvec must not add offset
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < NC; c++) begin
                idle_inputs();
                priv     = (p == 2) ? 2'd3 : 2'(p);
                mie      = c[1];
                sie      = c[2];
                edeleg   = 16'hB10A;
                mtvec    = 32'h0000_2001;
                exv      = 1'b1;
                code     = 4'(c);
                has_tval = c[0];
                tval     = 32'hF000_0000 + 32'(c);
                pc       = 32'h3000 + 32'(c * 4);
                fire();
                expect_trap(1'b0, 4'(c), priv, edeleg, has_tval);
            end
        end

        // R3 R10 R11: interrupt wins over same-cycle exception
        idle_inputs();
        priv = 2'd0; pend = 16'h0080; exv = 1'b1; code = 4'd2; has_tval = 1'b1;
        fire();
        expect_trap(1'b1, 4'd7, 2'd0, 16'h0000, 1'b0);
        idle_inputs();
        fire();
        chk("R11 one-cycle pulse", {31'd0, t_valid}, 32'd0);

        // R8 breakpoint enable for another privilege only: regular trap
        idle_inputs();
        priv = 2'd1; ebrk = 4'b1001; exv = 1'b1; code = 4'd3;
        fire();
        expect_trap(1'b0, 4'd3, 2'd1, 16'h0000, 1'b0);
        chk("R8 no debug entry", {31'd0, dmode}, 32'd0);

        // R8 R9 R12 debug entry, in-debug redirects, resume
        for (int p = 0; p < 3; p++) begin
            logic [1:0] pv;
            pv = (p == 2) ? 2'd3 : 2'(p);
            idle_inputs();
            priv = pv; ebrk = 4'(1 << pv); exv = 1'b1; code = 4'd3;
            pc = 32'h5000 + 32'(p * 16); edeleg = 16'hFFFF;
            fire();
            chk("R8 valid", {31'd0, t_valid}, 32'd1);
            chk("R8 dbg_wr", {29'd0, m_wr, s_wr, d_wr}, 32'd1);
            chk("R8 pc", n_pc, D_ENT);
            chk("R8 priv", {30'd0, n_priv}, 32'd3);
            chk("R8 dpc", epc, pc);
            chk("R8 old priv", {30'd0, pp}, {30'd0, pv});
            chk("R8 debug cause", cause, 32'd1);
            chk("R8 debug state", {31'd0, dmode}, 32'd1);

            idle_inputs();
            priv = pv; exv = 1'b1; code = 4'd3;
            fire();
            chk("R9 bkpt in debug pc", n_pc, D_ENT);
            chk("R9 bkpt in debug strobes", {28'd0, m_wr, s_wr, d_wr, t_valid}, 32'd1);

            idle_inputs();
            priv = pv; exv = 1'b1; code = 4'd5; has_tval = 1'b1; resume = 1'b1;
            fire();
            chk("R9 other exc in debug pc", n_pc, D_EXC);
            chk("R9 other exc strobes", {27'd0, tv_wr, m_wr, s_wr, d_wr, t_valid}, 32'd1);
            chk("R9 priv", {30'd0, n_priv}, 32'd3);
            chk("R9 still debug", {31'd0, dmode}, 32'd1);

            idle_inputs();
            priv = 2'd0; pend = 16'hFFFF;
            fire();
            chk("R9 interrupt ignored", {31'd0, t_valid}, 32'd0);

            idle_inputs();
            resume = 1'b1;
            fire();
            chk("R12 resume", {31'd0, dmode}, 32'd0);

            idle_inputs();
            priv = 2'd0; pend = 16'h0010;
            fire();
            expect_trap(1'b1, 4'd4, 2'd0, 16'h0000, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule